// File: doc/BRIEF.md
# Grouped Adder-Tree Window Accumulator with Rectification

This block sits right after a bank of parallel multipliers in a convolution engine. Each cycle it receives NGRP x NIF signed products, one product per multiplier. It splits them into NGRP groups of NIF, and each group is added up by its own pipelined binary adder tree. The fan-in of a tree equals the number of input feature maps of the layer, so every layer with the same input-map count shares the same tree instance.

The sum from each tree is then accumulated over the beats of a single kernel window. A beat marked `in_start` opens the window and one marked `in_last` closes it. When the window closes, each group's total is shifted right arithmetically by a fractional-bit count set per layer. The shifted value is rectified by its sign bit alone and then saturated to a narrow feature word. All groups present their results together, with a one-cycle strobe.

Control is a two-state machine. It runs on window markers that have been delayed to match the tree depth. In state `ST_IDLE` no window is open. The transition `IDLE->OPEN` is taken on a valid start beat that is not also last. `IDLE->IDLE (emit)` is taken on a valid beat that is both start and last. In state `ST_OPEN` valid beats add to the total. `OPEN->IDLE (emit)` is taken on a valid last beat. `OPEN->OPEN (restart)` is taken on a valid start beat without last.

Top module: `window_tree_relu`

## Requirements
- R1: Product j of group g occupies bits [(g*NIF+j)*PROD_W +: PROD_W] of `in_prod` as a signed PROD_W-bit value. Group g's window total is the sum of its NIF products over every accepted beat, and its result appears in `out_data[g*OUT_W +: OUT_W]`.
- R2: A window's result and `out_valid` become visible log2(NIF)+1 clock edges after the edge that samples its last beat, counting that sampling edge. With the default NIF=4 this is 3 edges.
- R3: A valid beat with `in_start` high loads its tree sums and discards any earlier partial total. Later valid beats add to the total until a valid beat with `in_last` high closes the window.
- R4: A valid beat with both `in_start` and `in_last` high forms a complete one-beat window. Such windows may follow one another on consecutive cycles, and each produces its own strobe.
- R5: A beat with `in_valid` low has no effect, whatever its markers are. A valid beat that arrives while no window is open and carries no `in_start` is discarded, and so is its `in_last`.
- R6: A valid start beat inside an open window restarts the window. The abandoned partial total produces no output.
- R7: Each output is the window total shifted right arithmetically by FRAC bits. It is forced to 0 when the sign bit is set and saturated to 2^(OUT_W-1)-1 (511 by default) when larger.
- R8: `out_valid` is high for exactly one cycle per completed window. `out_data` keeps its last value on every other cycle.
- R9: While `rst_n` is low and after it is released, `out_valid` and `out_data` are 0 and no window is open.
- R10: The total does not wrap for a window of KK_MAX beats in which every product is at the most positive or the most negative PROD_W-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier for products and markers |
| in_start | input | 1 | First beat of a kernel window |
| in_last | input | 1 | Final beat of a kernel window |
| in_prod | input | NGRP*NIF*PROD_W | Packed signed products, group-major |
| out_valid | output | 1 | One-cycle strobe per completed window |
| out_data | output | NGRP*OUT_W | Rectified, saturated group results |

## Verification
The hardest cases to reach are the marker combinations that fall outside a clean window. These are a restart while a window is open, orphan valid beats and closing markers with no open window, and markers carried on invalid beats. Each of them has to reach the controller after the tree delay, possibly on back-to-back cycles. The stimulus drives dedicated phases for these cases: restarts partway through long windows, stray last markers between windows, bursts of one-beat windows, and idle beats that carry start and last markers with valid low. Windows of all-maximum and all-minimum products drive the accumulator to its width limits. A behavioural model compares every output on every clock.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } win_state_t;

    typedef struct packed {
        logic vld;
        logic st;
        logic lst;
    } mark_t;

endpackage

// File: rtl/wtr_adder_tree.sv
module wtr_adder_tree #(
    parameter int PROD_W = 18,
    parameter int NIF    = 4,
    localparam int LEVELS = $clog2(NIF),
    localparam int TREE_W = PROD_W + LEVELS
) (
    input  logic                      clk,
    input  logic [NIF*PROD_W-1:0]     prod_i,
    output logic signed [TREE_W-1:0]  sum_o
);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        logic signed [TREE_W-1:0] node [NIF >> l];
        if (l == 0) begin : g_leaf
            always_comb begin
                for (int i = 0; i < NIF; i++) begin
                    node[i] = {{LEVELS{prod_i[i*PROD_W + PROD_W - 1]}},
                               prod_i[i*PROD_W +: PROD_W]};
                end
            end
        end else begin : g_stage
            always_ff @(posedge clk) begin
                for (int i = 0; i < (NIF >> l); i++) begin
                    node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
                end
            end
        end
    end

    assign sum_o = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/wtr_window_ctrl.sv
module wtr_window_ctrl
    import wtr_pkg::*;
#(
    parameter int LEVELS = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mark_t mark_i,
    output logic  acc_load,
    output logic  acc_add,
    output logic  emit,
    output logic  out_valid
);

    mark_t      dly [LEVELS];
    mark_t      d;
    win_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LEVELS; i++) dly[i] <= '0;
        end else begin
            dly[0] <= mark_i;
            for (int i = 1; i < LEVELS; i++) dly[i] <= dly[i-1];
        end
    end

    assign d = dly[LEVELS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (d.vld && d.st && !d.lst) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (d.vld && d.lst) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_load = 1'b0;
        acc_add  = 1'b0;
        emit     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_load = d.vld && d.st;
                emit     = d.vld && d.st && d.lst;
            end
            ST_OPEN: begin
                acc_load = d.vld && d.st;
                acc_add  = d.vld && !d.st;
                emit     = d.vld && d.lst;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= emit;
    end

    AST_LOAD_ADD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_load && acc_add)); // R3
    AST_IDLE_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !acc_add); // R5
    AST_EMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> (state_q == ST_IDLE)); // R4

endmodule

// File: rtl/wtr_accum_relu.sv
module wtr_accum_relu #(
    parameter int TREE_W = 20,
    parameter int ACC_W  = 24,
    parameter int OUT_W  = 10,
    parameter int FRAC   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TREE_W-1:0] tree_i,
    input  logic                     acc_load,
    input  logic                     acc_add,
    input  logic                     emit,
    output logic [OUT_W-1:0]         out_o
);

    localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};

    logic signed [ACC_W-1:0] acc_q, tree_x, total, shifted;
    logic [OUT_W-1:0]        narrow;

    assign tree_x = {{(ACC_W-TREE_W){tree_i[TREE_W-1]}}, tree_i};
    assign total  = acc_load ? tree_x : (acc_q + tree_x);
    assign shifted = total >>> FRAC;

    always_comb begin
        if (shifted[ACC_W-1])
            narrow = '0;
        else if (|shifted[ACC_W-2:OUT_W-1])
            narrow = MAXV;
        else
            narrow = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            out_o <= '0;
        end else begin
            if (acc_load || acc_add) acc_q <= total;
            if (emit) out_o <= narrow;
        end
    end

    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> !out_o[OUT_W-1]); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> $stable(out_o)); // R8

endmodule

// File: rtl/window_tree_relu.sv
module window_tree_relu
    import wtr_pkg::*;
#(
    parameter int PROD_W = 18,
    parameter int NIF    = 4,
    parameter int NGRP   = 2,
    parameter int KK_MAX = 9,
    parameter int OUT_W  = 10,
    parameter int FRAC   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_start,
    input  logic                        in_last,
    input  logic [NGRP*NIF*PROD_W-1:0]  in_prod,
    output logic                        out_valid,
    output logic [NGRP*OUT_W-1:0]       out_data
);

    localparam int LEVELS = $clog2(NIF);
    localparam int TREE_W = PROD_W + LEVELS;
    localparam int ACC_W  = PROD_W + $clog2(NIF * KK_MAX);

    mark_t mark_in;
    logic  acc_load, acc_add, emit;

    assign mark_in = '{vld: in_valid, st: in_start, lst: in_last};

    wtr_window_ctrl #(.LEVELS(LEVELS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_i    (mark_in),
        .acc_load  (acc_load),
        .acc_add   (acc_add),
        .emit      (emit),
        .out_valid (out_valid)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic signed [TREE_W-1:0] tsum;

        wtr_adder_tree #(.PROD_W(PROD_W), .NIF(NIF)) tree_i (
            .clk    (clk),
            .prod_i (in_prod[g*NIF*PROD_W +: NIF*PROD_W]),
            .sum_o  (tsum)
        );

        wtr_accum_relu #(
            .TREE_W (TREE_W),
            .ACC_W  (ACC_W),
            .OUT_W  (OUT_W),
            .FRAC   (FRAC)
        ) acc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tree_i   (tsum),
            .acc_load (acc_load),
            .acc_add  (acc_add),
            .emit     (emit),
            .out_o    (out_data[g*OUT_W +: OUT_W])
        );
    end

endmodule

// File: tb/window_tree_relu_tb.sv
module window_tree_relu_tb_top;

    localparam int PROD_W = 18;
    localparam int NIF    = 4;
    localparam int NGRP   = 2;
    localparam int KK_MAX = 9;
    localparam int OUT_W  = 10;
    localparam int FRAC   = 4;
    localparam int NM     = NIF * NGRP;
    localparam int LAT    = 2;          // log2(NIF) edges after the sampling edge
    localparam int MAXO   = 511;
    localparam int PMAX   = 131071;
    localparam int PMIN   = -131072;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [NM*PROD_W-1:0] in_prod = '0;
    logic out_valid;
    logic [NGRP*OUT_W-1:0] out_data;

    always #5 clk = ~clk;

    window_tree_relu #(
        .PROD_W(PROD_W), .NIF(NIF), .NGRP(NGRP),
        .KK_MAX(KK_MAX), .OUT_W(OUT_W), .FRAC(FRAC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
        .in_prod(in_prod),
        .out_valid(out_valid), .out_data(out_data)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cur_p [NM];
    string cur_tag = "R1";

    // reference state
    bit      r_open = 0;
    longint  r_acc [NGRP];
    int      r_hold [NGRP];
    bit      e_v   [LAT+1];
    int      e_d   [LAT+1][NGRP];
    string   e_tag [LAT+1];

    function automatic int narrow_ref(longint a);
        longint s = a >>> FRAC;
        if (s < 0) return 0;
        if (s > MAXO) return MAXO;
        return int'(s);
    endfunction

    task automatic model_and_check();
        bit accepted;
        bit nv = 0;
        for (int i = 0; i < LAT; i++) begin
            e_v[i] = e_v[i+1];
            e_tag[i] = e_tag[i+1];
            for (int g = 0; g < NGRP; g++) e_d[i][g] = e_d[i+1][g];
        end
        vectors++;
        if (out_valid !== e_v[0]) begin
            miscompares++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", e_tag[0], out_valid, e_v[0]);
        end
        for (int g = 0; g < NGRP; g++) begin
            vectors++;
            if (int'(out_data[g*OUT_W +: OUT_W]) != e_d[0][g]) begin
                miscompares++;
                $display("FAIL %s (R8 hold/R1 group %0d) out_data actual=%0d expected=%0d",
                         e_tag[0], g, out_data[g*OUT_W +: OUT_W], e_d[0][g]);
            end
        end
        // beat sampled at the edge just before this negedge
        accepted = in_valid && (in_start || r_open);
        if (accepted) begin
            for (int g = 0; g < NGRP; g++) begin
                longint s = 0;
                for (int j = 0; j < NIF; j++) s += cur_p[g*NIF+j];
                if (in_start) r_acc[g] = s;
                else          r_acc[g] = r_acc[g] + s;
            end
        end
        if (accepted && in_last) begin
            nv = 1;
            r_open = 0;
            for (int g = 0; g < NGRP; g++) r_hold[g] = narrow_ref(r_acc[g]);
        end else if (in_valid && in_start) begin
            r_open = 1;
        end
        e_v[LAT] = nv;
        e_tag[LAT] = cur_tag;
        for (int g = 0; g < NGRP; g++) e_d[LAT][g] = r_hold[g];
    endtask

    task automatic drive(bit v, bit s, bit l, int mode);
        @(negedge clk);
        model_and_check();
        in_valid = v; in_start = s; in_last = l;
        for (int i = 0; i < NM; i++) begin
            case (mode)
                1: cur_p[i] = PMAX;
                2: cur_p[i] = PMIN;
                3: cur_p[i] = (int'($urandom_range(1023)) - 512) * (int'($urandom_range(255)) - 128);
                default: cur_p[i] = int'($urandom_range(400)) - 200;
            endcase
            in_prod[i*PROD_W +: PROD_W] = cur_p[i][PROD_W-1:0];
        end
    endtask

    task automatic window(int n, int mode);
        for (int b = 0; b < n; b++) drive(1, b == 0, b == n - 1, mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i <= LAT; i++) begin
            e_v[i] = 0; e_tag[i] = "R9";
            for (int g = 0; g < NGRP; g++) e_d[i][g] = 0;
        end
        for (int g = 0; g < NGRP; g++) begin r_acc[g] = 0; r_hold[g] = 0; end
        for (int i = 0; i < NM; i++) cur_p[i] = 0;
        repeat (3) @(negedge clk);
        // R9: outputs quiet while reset is held
        vectors++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            miscompares++;
            $display("FAIL R9 reset outputs actual=%0b/%0h expected=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;
        cur_tag = "R9";
        repeat (3) drive(0, 0, 0, 0);

        // R1 R2 R3: full 3x3 windows, back to back and with gaps
        cur_tag = "R3";
        for (int w = 0; w < 6; w++) window(9, 0);
        for (int w = 0; w < 4; w++) begin
            drive(1, 1, 0, 0); drive(0, 0, 0, 0); drive(1, 0, 0, 0);
            drive(0, 1, 1, 0); drive(1, 0, 1, 0); drive(0, 0, 0, 0);
        end
        cur_tag = "R2";
        for (int w = 0; w < 4; w++) begin window(4, 3); repeat (5) drive(0, 0, 0, 0); end

        // R4: one-beat windows on consecutive cycles
        cur_tag = "R4";
        for (int w = 0; w < 8; w++) drive(1, 1, 1, 0);
        drive(0, 0, 0, 0);

        // R5: orphan beats, stray last, markers on invalid beats
        cur_tag = "R5";
        drive(1, 0, 0, 1); drive(1, 0, 1, 1); drive(0, 1, 0, 0); drive(0, 0, 1, 0);
        drive(0, 1, 1, 0); drive(1, 0, 0, 2); drive(1, 0, 1, 0);
        window(3, 0);
        drive(1, 0, 1, 1); drive(1, 0, 0, 1);
        repeat (4) drive(0, 0, 0, 0);

        // R6: restart partway through an open window
        cur_tag = "R6";
        for (int w = 0; w < 3; w++) begin
            drive(1, 1, 0, 1); drive(1, 0, 0, 1); drive(1, 0, 0, 1);
            window(5, 0);
        end
        drive(1, 1, 0, 2); drive(1, 1, 1, 0);
        repeat (4) drive(0, 0, 0, 0);

        // R7 R10: saturation, rectification, extremes over KK_MAX beats
        cur_tag = "R10";
        window(KK_MAX, 1);
        window(KK_MAX, 2);
        cur_tag = "R7";
        for (int w = 0; w < 10; w++) window(3, 3);
        window(2, 2);
        window(1, 1);
        for (int w = 0; w < 10; w++) window(1, 0);

        // R8: long idle stretch with held data
        cur_tag = "R8";
        repeat (10) drive(0, 0, 0, 0);
        window(9, 3);
        repeat (8) drive(0, 1, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule